// File: doc/BRIEF.md
# Cyclic Reservation Table Latency Analyzer

This block analyzes a small pipeline reservation table for use under modulo scheduling. Software or a scheduler front end presents a bit matrix of stages by time steps together with a runtime initiation interval (II). The block wraps the table onto exactly II columns, which pads a short table with empty columns and places a mark from column j of a long table at column j mod II. From the wrapped table it derives which initiation latencies collide in some stage and which are free. It also reports two upper bounds on how many initiations fit in one interval.

The engine is sequential. A start pulse latches the table and the interval. The block wraps one stage row per cycle, then tests one candidate latency per cycle, then spends one cycle on the bounds, and pulses done. An interval outside the supported range, or one that wraps two marks of a single row onto the same column, is reported as illegal instead.

Top module: `crtLatencyAnalyzer`

## Requirements
- R1: A mark at row r, column j of the input table takes part in the analysis at wrapped column j mod II; table columns at or past II need no special handling and columns of the wrapped table with no source mark stay empty.
- R2: Latency f (0 < f < II) is forbidden when some row of the wrapped table holds marks at columns a and b with (b - a) mod II = f; latency 0 is always forbidden. For a row with marks at columns 0 and 2 and II = 6 the forbidden set is {0,2,4}.
- R3: If two marks of one row wrap to the same column, illegal is 1 and forbidMask, permitMask, maxMarks and all three bounds are 0.
- R4: An interval of 0 or greater than MAX_II gives illegal = 1 with all other result outputs 0.
- R5: Bit f of permitMask is 1 exactly when f < II and latency f is not forbidden; bits at or above II are 0 in both masks; if p is permitted then II - p is permitted.
- R6: maxMarks is the largest mark count of any input row; resBound is floor(II / maxMarks), or II when the table is empty.
- R7: permBound is the number of permitted latencies plus one, and initBound is the larger of resBound and permBound.
- R8: done is a single-cycle pulse, raised MAX_STAGES + II + 1 cycles after the edge that accepts start for a legal run, MAX_STAGES + 1 cycles after it when a wrap collision occurs, and 1 cycle after it for an out-of-range interval; busy is 1 from the accepting edge until done.
- R9: A start pulse while busy is ignored; the running analysis completes on its originally latched table and interval.
- R10: All result outputs hold their values between completions, whatever happens on the table and interval inputs.
- R11: After reset busy, done, illegal, both masks, maxMarks and all bounds are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an analysis when idle |
| iiIn | input | $clog2(MAX_II+1) | Initiation interval |
| tableBits | input | MAX_STAGES*MAX_COLS | Row r occupies bits [r*MAX_COLS +: MAX_COLS], bit j = time step j |
| busy | output | 1 | Analysis in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Interval out of range or wrap collision |
| forbidMask | output | MAX_II | Bit f set when latency f is forbidden |
| permitMask | output | MAX_II | Bit f set when latency f is permitted |
| maxMarks | output | $clog2(MAX_COLS+1) | Largest mark count in any row |
| resBound | output | $clog2(MAX_II+1) | Resource bound on initiations |
| permBound | output | $clog2(MAX_II+1) | Permitted-latency bound on initiations |
| initBound | output | $clog2(MAX_II+1) | Larger of the two bounds |

## Verification
A wrong wrapped row or a missed collision shows up at the next done pulse as a wrong illegal flag or a mask that breaks the II - p symmetry, so every run exposes it within MAX_STAGES + II + 1 cycles of start. A miscounted latency scan shows as a done pulse on the wrong cycle or a stray bit at or above II. A lost hold shows as result outputs that move between done pulses, which the bench probes by changing the inputs with no start.

// File: rtl/crtPkg.sv
package crtPkg;
  typedef struct packed {
    logic load;
    logic fold;
    logic scan;
    logic finish;
  } crtStrobe_t;
endpackage

// File: rtl/crtCtrl.sv
module crtCtrl
  import crtPkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int MAX_II     = 16,
  localparam int RW  = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int IIW = $clog2(MAX_II + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           rangeBad,
  input  logic           collAny,
  input  logic [IIW-1:0] iiReg,
  output crtStrobe_t     strobe,
  output logic [RW-1:0]  rowIdx,
  output logic [IIW-1:0] latIdx,
  output logic           busy,
  output logic           done
);

  typedef enum logic [1:0] {S_IDLE, S_FOLD, S_SCAN, S_FIN} state_t;
  state_t state;

  localparam logic [RW-1:0] LAST_ROW = RW'(MAX_STAGES - 1);

  always_comb begin
    strobe.load   = (state == S_IDLE) && start;
    strobe.fold   = (state == S_FOLD);
    strobe.scan   = (state == S_SCAN);
    strobe.finish = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      rowIdx <= '0;
      latIdx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            rowIdx <= '0;
            state  <= rangeBad ? S_FIN : S_FOLD;
          end
        end
        S_FOLD: begin
          if (rowIdx == LAST_ROW) begin
            latIdx <= '0;
            state  <= collAny ? S_FIN : S_SCAN;
          end else begin
            rowIdx <= rowIdx + RW'(1);
          end
        end
        S_SCAN: begin
          if (latIdx == iiReg - IIW'(1)) state <= S_FIN;
          else latIdx <= latIdx + IIW'(1);
        end
        default: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: the engine is idle when done is seen
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R8: the latency scan never runs past the interval
  a_r8_scan_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN) |-> (latIdx < iiReg));

endmodule

// File: rtl/crtBounds.sv
module crtBounds #(
  parameter int MAX_II = 16,
  parameter int DW     = 5,
  localparam int IIW   = $clog2(MAX_II + 1)
) (
  input  logic [IIW-1:0]    iiVal,
  input  logic [DW-1:0]     dmaxVal,
  input  logic [MAX_II-1:0] permitBits,
  output logic [IIW-1:0]    resB,
  output logic [IIW-1:0]    permB,
  output logic [IIW-1:0]    initB
);

  int quot;

  always_comb begin
    if (dmaxVal == '0) quot = int'(iiVal);
    else               quot = int'(iiVal) / int'(dmaxVal);
    resB  = IIW'(quot);
    permB = IIW'($countones(permitBits) + 1);
    initB = (resB > permB) ? resB : permB;
  end

endmodule

// File: rtl/crtDatapath.sv
module crtDatapath
  import crtPkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int MAX_COLS   = 24,
  parameter int MAX_II     = 16,
  localparam int RW  = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int IIW = $clog2(MAX_II + 1),
  localparam int LW  = (MAX_II > 1) ? $clog2(MAX_II) : 1,
  localparam int DW  = $clog2(MAX_COLS + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  crtStrobe_t                     strobe,
  input  logic [RW-1:0]                  rowIdx,
  input  logic [IIW-1:0]                 latIdx,
  input  logic [MAX_STAGES*MAX_COLS-1:0] tableBits,
  input  logic [IIW-1:0]                 iiIn,
  output logic                           rangeBad,
  output logic                           collAny,
  output logic [IIW-1:0]                 iiReg,
  output logic                           illegal,
  output logic [MAX_II-1:0]              forbidMask,
  output logic [MAX_II-1:0]              permitMask,
  output logic [DW-1:0]                  maxMarks,
  output logic [IIW-1:0]                 resBound,
  output logic [IIW-1:0]                 permBound,
  output logic [IIW-1:0]                 initBound
);

  logic [MAX_STAGES-1:0][MAX_COLS-1:0] tbl;
  logic [MAX_STAGES-1:0][MAX_II-1:0]   cyc;
  logic                                badReg, collReg;
  logic [DW-1:0]                       dmaxReg;
  logic [MAX_II-1:0]                   forbidAcc;
  logic [IIW-1:0]                      iiDone;

  logic [IIW-1:0]    iiSafe;
  logic [LW-1:0]     colOf [MAX_COLS];
  logic [MAX_COLS-1:0] rowBits;
  logic [MAX_II-1:0] foldRow;
  logic              rowColl;
  logic [DW-1:0]     rowCount;
  logic              hit;
  int                scanIdx;
  logic [MAX_II-1:0] validMask, forbidNext, permitNext;
  logic [IIW-1:0]    resNext, permNext, initNext;

  assign rangeBad = (iiIn == '0) || (iiIn > IIW'(MAX_II));
  assign iiSafe   = (iiReg == '0) ? IIW'(1) : iiReg;

  // wrapped column of every table column for the latched interval
  for (genvar j = 0; j < MAX_COLS; j++) begin : g_col
    assign colOf[j] = LW'(j % int'(iiSafe));
  end

  // wrap the current row, detecting two marks landing on one column
  always_comb begin
    rowBits = tbl[rowIdx];
    foldRow = '0;
    rowColl = 1'b0;
    for (int j = 0; j < MAX_COLS; j++) begin
      if (rowBits[j]) begin
        if (foldRow[colOf[j]]) rowColl = 1'b1;
        foldRow[colOf[j]] = 1'b1;
      end
    end
    rowCount = DW'($countones(rowBits));
  end

  assign collAny = collReg | (strobe.fold & rowColl);

  // does any wrapped row overlap itself when shifted by latIdx
  always_comb begin
    hit     = 1'b0;
    scanIdx = 0;
    for (int r = 0; r < MAX_STAGES; r++) begin
      for (int c = 0; c < MAX_II; c++) begin
        if (c < int'(iiReg)) begin
          scanIdx = c + int'(latIdx);
          if (scanIdx >= int'(iiReg)) scanIdx = scanIdx - int'(iiReg);
          if (cyc[r][c] && cyc[r][LW'(scanIdx)]) hit = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int c = 0; c < MAX_II; c++) validMask[c] = (c < int'(iiReg));
    forbidNext = (forbidAcc | MAX_II'(1)) & validMask;
    permitNext = ~(forbidAcc | MAX_II'(1)) & validMask;
  end

  crtBounds #(.MAX_II(MAX_II), .DW(DW)) uBounds (
    .iiVal     (iiReg),
    .dmaxVal   (dmaxReg),
    .permitBits(permitNext),
    .resB      (resNext),
    .permB     (permNext),
    .initB     (initNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tbl        <= '0;
      cyc        <= '0;
      iiReg      <= '0;
      badReg     <= 1'b0;
      collReg    <= 1'b0;
      dmaxReg    <= '0;
      forbidAcc  <= '0;
      iiDone     <= '0;
      illegal    <= 1'b0;
      forbidMask <= '0;
      permitMask <= '0;
      maxMarks   <= '0;
      resBound   <= '0;
      permBound  <= '0;
      initBound  <= '0;
    end else begin
      if (strobe.load) begin
        tbl       <= tableBits;
        iiReg     <= iiIn;
        badReg    <= rangeBad;
        collReg   <= 1'b0;
        dmaxReg   <= '0;
        forbidAcc <= '0;
        cyc       <= '0;
      end
      if (strobe.fold) begin
        cyc[rowIdx] <= foldRow;
        collReg     <= collReg | rowColl;
        if (rowCount > dmaxReg) dmaxReg <= rowCount;
      end
      if (strobe.scan) begin
        forbidAcc[LW'(latIdx)] <= hit;
      end
      if (strobe.finish) begin
        iiDone <= iiReg;
        if (badReg || collReg) begin
          illegal    <= 1'b1;
          forbidMask <= '0;
          permitMask <= '0;
          maxMarks   <= '0;
          resBound   <= '0;
          permBound  <= '0;
          initBound  <= '0;
        end else begin
          illegal    <= 1'b0;
          forbidMask <= forbidNext;
          permitMask <= permitNext;
          maxMarks   <= dmaxReg;
          resBound   <= resNext;
          permBound  <= permNext;
          initBound  <= initNext;
        end
      end
    end
  end

  // symmetry of the reported permitted set about the interval
  logic symOk;
  always_comb begin
    symOk = 1'b1;
    for (int p = 1; p < MAX_II; p++) begin
      if (p < int'(iiDone) && permitMask[p] && !permitMask[LW'(int'(iiDone) - p)])
        symOk = 1'b0;
    end
  end

  // R5: permitted set closed under p -> II - p
  a_r5_permit_symmetric: assert property (@(posedge clk) disable iff (!rstN)
    symOk);

  // R5: a latency is never both forbidden and permitted
  a_r5_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    (forbidMask & permitMask) == '0);

  // R2: latency zero reported forbidden on every legal result
  a_r2_zero_forbidden: assert property (@(posedge clk) disable iff (!rstN)
    (iiDone != '0 && !illegal) |-> forbidMask[0]);

  // R3: an illegal result carries no masks or bounds
  a_r3_illegal_zero: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (forbidMask == '0 && permitMask == '0 && initBound == '0));

  // R7: combined bound dominates both components
  a_r7_init_max: assert property (@(posedge clk) disable iff (!rstN)
    (initBound >= resBound) && (initBound >= permBound));

  // R10: results move only on the cycle after a finish strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> ($stable(forbidMask) && $stable(permitMask) &&
                        $stable(illegal) && $stable(initBound) && $stable(maxMarks)));

endmodule

// File: rtl/crtLatencyAnalyzer.sv
module crtLatencyAnalyzer
  import crtPkg::*;
#(
  parameter int MAX_STAGES = 8,
  parameter int MAX_COLS   = 24,
  parameter int MAX_II     = 16,
  localparam int RW  = (MAX_STAGES > 1) ? $clog2(MAX_STAGES) : 1,
  localparam int IIW = $clog2(MAX_II + 1),
  localparam int DW  = $clog2(MAX_COLS + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [IIW-1:0]                 iiIn,
  input  logic [MAX_STAGES*MAX_COLS-1:0] tableBits,
  output logic                           busy,
  output logic                           done,
  output logic                           illegal,
  output logic [MAX_II-1:0]              forbidMask,
  output logic [MAX_II-1:0]              permitMask,
  output logic [DW-1:0]                  maxMarks,
  output logic [IIW-1:0]                 resBound,
  output logic [IIW-1:0]                 permBound,
  output logic [IIW-1:0]                 initBound
);

  crtStrobe_t     strobe;
  logic [RW-1:0]  rowIdx;
  logic [IIW-1:0] latIdx;
  logic [IIW-1:0] iiReg;
  logic           rangeBad, collAny;

  crtCtrl #(.MAX_STAGES(MAX_STAGES), .MAX_II(MAX_II)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .rangeBad(rangeBad),
    .collAny (collAny),
    .iiReg   (iiReg),
    .strobe  (strobe),
    .rowIdx  (rowIdx),
    .latIdx  (latIdx),
    .busy    (busy),
    .done    (done)
  );

  crtDatapath #(.MAX_STAGES(MAX_STAGES), .MAX_COLS(MAX_COLS), .MAX_II(MAX_II)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rowIdx    (rowIdx),
    .latIdx    (latIdx),
    .tableBits (tableBits),
    .iiIn      (iiIn),
    .rangeBad  (rangeBad),
    .collAny   (collAny),
    .iiReg     (iiReg),
    .illegal   (illegal),
    .forbidMask(forbidMask),
    .permitMask(permitMask),
    .maxMarks  (maxMarks),
    .resBound  (resBound),
    .permBound (permBound),
    .initBound (initBound)
  );

endmodule

// File: tb/crtLatencyAnalyzer_test.sv
`timescale 1ns/1ps
module crtLatencyAnalyzer_test;
  localparam int MAX_STAGES = 8;
  localparam int MAX_COLS   = 24;
  localparam int MAX_II     = 16;
  localparam int IIW = $clog2(MAX_II + 1);
  localparam int DW  = $clog2(MAX_COLS + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [IIW-1:0] iiIn = '0;
  logic [MAX_STAGES*MAX_COLS-1:0] tableBits = '0;
  logic busy, done, illegal;
  logic [MAX_II-1:0] forbidMask, permitMask;
  logic [DW-1:0] maxMarks;
  logic [IIW-1:0] resBound, permBound, initBound;

  always #2.5 clk = ~clk;

  crtLatencyAnalyzer #(.MAX_STAGES(MAX_STAGES), .MAX_COLS(MAX_COLS), .MAX_II(MAX_II)) uut (
    .clk(clk), .rstN(rstN), .start(start), .iiIn(iiIn), .tableBits(tableBits),
    .busy(busy), .done(done), .illegal(illegal), .forbidMask(forbidMask),
    .permitMask(permitMask), .maxMarks(maxMarks), .resBound(resBound),
    .permBound(permBound), .initBound(initBound)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  bit expIll;
  int expCycles, expDmax, expRes, expPerm, expInit;
  logic [MAX_II-1:0] expForbid, expPermit;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic mark(input int r, input int c);
    tableBits[r*MAX_COLS + c] = 1'b1;
  endtask

  // reference model: pairwise distances of original marks, taken mod II
  task automatic computeExp();
    int ii = int'(iiIn);
    bit coll = 1'b0;
    expForbid = '0; expPermit = '0; expDmax = 0;
    if (ii == 0 || ii > MAX_II) begin
      expIll = 1'b1; expCycles = 1;
    end else begin
      for (int r = 0; r < MAX_STAGES; r++) begin
        int cnt = 0;
        for (int a = 0; a < MAX_COLS; a++) begin
          if (tableBits[r*MAX_COLS + a]) begin
            cnt++;
            for (int b = a + 1; b < MAX_COLS; b++) begin
              if (tableBits[r*MAX_COLS + b]) begin
                int d = (b - a) % ii;
                if (d == 0) coll = 1'b1;
                else begin expForbid[d] = 1'b1; expForbid[ii - d] = 1'b1; end
              end
            end
          end
        end
        if (cnt > expDmax) expDmax = cnt;
      end
      expIll = coll;
      expCycles = coll ? MAX_STAGES + 1 : MAX_STAGES + ii + 1;
      expForbid[0] = 1'b1;
      for (int f = 0; f < MAX_II; f++) expPermit[f] = (f < ii) && !expForbid[f];
    end
    if (expIll) begin
      expForbid = '0; expPermit = '0; expDmax = 0;
      expRes = 0; expPerm = 0; expInit = 0;
    end else begin
      expRes  = (expDmax == 0) ? ii : ii / expDmax;
      expPerm = $countones(expPermit) + 1;
      expInit = (expRes > expPerm) ? expRes : expPerm;
    end
  endtask

  task automatic checkOutputs(input string tag);
    chk(illegal == expIll, expIll ? "R3/R4" : "R3", {tag, " illegal"}, illegal, expIll);
    chk(forbidMask == expForbid, "R2", {tag, " forbid (R1 wrap)"}, forbidMask, expForbid);
    chk(permitMask == expPermit, "R5", {tag, " permit"}, permitMask, expPermit);
    chk(int'(maxMarks) == expDmax, "R6", {tag, " maxMarks"}, maxMarks, expDmax);
    chk(int'(resBound) == expRes, "R6", {tag, " resBound"}, resBound, expRes);
    chk(int'(permBound) == expPerm, "R7", {tag, " permBound"}, permBound, expPerm);
    chk(int'(initBound) == expInit, "R7", {tag, " initBound"}, initBound, expInit);
  endtask

  task automatic runCase(input string tag, input bit midPulse);
    int n = 0;
    bit sym = 1'b1;
    computeExp();
    @(negedge clk); start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    chk(busy == 1'b1, "R8", {tag, " busy after accept"}, busy, 1);
    while (!done && n < 2000) begin
      if (midPulse && n == 3) begin
        start = 1'b1; iiIn = IIW'(3); tableBits = ~tableBits;
      end
      if (midPulse && n == 4) start = 1'b0;
      @(posedge clk); #1; n++;
    end
    chk(n == expCycles, "R8", {tag, " done latency"}, n, expCycles);
    checkOutputs(tag);
    for (int p = 1; p < MAX_II; p++) begin
      int q = int'(uut.uPath.iiDone) - p;
      if (p < int'(iiIn) && q > 0 && q < MAX_II && permitMask[p] && !permitMask[q]) sym = 1'b0;
    end
    @(posedge clk); #1;
    chk(done == 1'b0 && busy == 1'b0, "R8", {tag, " done is a pulse"}, {busy, done}, 0);
    if (!midPulse) chk(sym, "R5", {tag, " permit symmetry"}, sym, 1);
  endtask

  task automatic symCheck(input string tag, input int ii);
    bit sym = 1'b1;
    for (int p = 1; p < ii; p++)
      if (permitMask[p] && !permitMask[ii - p]) sym = 1'b0;
    chk(sym, "R5", {tag, " II-p symmetry"}, permitMask, expPermit);
  endtask

  initial begin
    void'($urandom(32'd20250117));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk(busy == 1'b0 && done == 1'b0, "R11", "reset busy/done", {busy, done}, 0);
    chk(illegal == 1'b0 && forbidMask == '0 && permitMask == '0, "R11", "reset result",
        {illegal, forbidMask, permitMask}, 0);
    chk(maxMarks == '0 && initBound == '0 && resBound == '0 && permBound == '0, "R11",
        "reset bounds", {maxMarks, initBound}, 0);
    @(negedge clk); rstN = 1'b1;

    // R2: row {0,2}, row {1,3}, row {2} with II=6
    tableBits = '0; mark(0, 0); mark(0, 2); mark(1, 1); mark(1, 3); mark(2, 2);
    iiIn = IIW'(6);
    runCase("II6 example", 1'b0);
    chk(forbidMask == 16'h0015 && permitMask == 16'h002A, "R2", "II6 forbid {0,2,4}",
        forbidMask, 16'h0015);
    symCheck("II6", 6);

    // same table wrapped onto II=3
    iiIn = IIW'(3);
    runCase("II3 fold", 1'b0);

    // R1: marks past II wrap; row {0,20} with II=7 -> distance 6
    tableBits = '0; mark(0, 0); mark(0, 20); mark(4, 5); iiIn = IIW'(7);
    runCase("II7 wrap", 1'b0);
    chk(forbidMask == 16'h0043, "R1", "II7 wrapped distance", forbidMask, 16'h0043);

    // R3: collision row {0,4} with II=4
    tableBits = '0; mark(3, 0); mark(3, 4); iiIn = IIW'(4);
    runCase("collide", 1'b0);

    // R4: out-of-range intervals
    iiIn = IIW'(0);  runCase("II0", 1'b0);
    iiIn = IIW'(17); runCase("II17", 1'b0);

    // R6: empty table, full interval
    tableBits = '0; iiIn = IIW'(16);
    runCase("empty", 1'b0);
    chk(resBound == IIW'(16), "R6", "empty resBound", resBound, 16);

    // II=1 single marks, then collision at II=1
    tableBits = '0; mark(7, 23); iiIn = IIW'(1);
    runCase("II1", 1'b0);
    mark(7, 22);
    runCase("II1 coll", 1'b0);

    // R9: start during busy ignored
    tableBits = '0; mark(0, 0); mark(0, 2); iiIn = IIW'(6);
    runCase("busy start", 1'b1);

    // R10: outputs hold while inputs change without start
    tableBits = '0; mark(1, 0); mark(1, 1); mark(2, 3); iiIn = IIW'(9);
    runCase("pre hold", 1'b0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      iiIn = IIW'($urandom_range(0, 31));
      tableBits = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    end
    @(posedge clk); #1;
    checkOutputs("R10 hold");

    // random sparse tables
    for (int t = 0; t < 40; t++) begin
      tableBits = '0;
      for (int r = 0; r < MAX_STAGES; r++)
        for (int c = 0; c < MAX_COLS; c++)
          if ($urandom_range(0, 9) == 0) mark(r, c);
      iiIn = IIW'($urandom_range(1, MAX_II));
      runCase($sformatf("rand%0d", t), 1'b0);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule